// File: doc/BRIEF.md
# DLL delay code stepper

This block keeps the delay setting of one byte lane as a mixed-radix code. The code has four fields: a coarse bit, a clock-delay field, a tap field and a phase-interpolator field. Training logic loads a starting code. It then pulses a step strobe, once per trial, to move the lane one delay increment later.

Each step works like an odometer. The interpolator is the fastest digit. The number of taps per clock-delay position depends on the selected memory speed. When the count passes the last clock-delay position, it moves into the coarse bit and drops the clock-delay field back by one. When no further increment exists, the code is frozen and a sticky error flag is raised.

With every load and every step, the block also derives two bypass control bits (enable, select) for the delay line. It compares the resulting tap and interpolator values against a pair of thresholds that depends on the speed.

Top module: `dcs_stepper`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the code is all zeros, the error flag is 0 and the bypass bits are enable=1, select=1.
- R2: A load pulse makes the code equal the load fields from the next cycle on and clears the error flag. Load takes priority over a step strobe in the same cycle.
- R3: A step with the interpolator below 6 increments only the interpolator. A step with the interpolator at 6 and tap below its maximum sets the interpolator to 0 and increments tap.
- R4: The tap maximum is selected by the speed input: code 0 gives 12, code 1 gives 10, code 2 gives 13, and the unused code 3 behaves like code 0.
- R5: A step with tap at its maximum, the interpolator at 6 and clock-delay below 2 clears tap and the interpolator and increments clock-delay.
- R6: A step with clock-delay at 2 and coarse at 0, and the lower fields at their limits, clears tap and the interpolator, sets clock-delay to 1 and coarse to 1.
- R7: A step with all fields at their limits (coarse 1, clock-delay 2, tap at maximum, interpolator 6) leaves the code unchanged and sets the error flag. The flag stays set through further steps until the next load.
- R8: The bypass bits are computed from the code written by each load or step. Each speed has four thresholds (lower tap, upper tap, lower interpolator, upper interpolator): 3/10/2/3 for codes 0 and 3, 2/8/6/7 for code 1, and 3/11/6/4 for code 2. The bits are:
  - enable=1, select=1 when tap is below the lower tap threshold, or equal to it with the interpolator below the lower interpolator threshold;
  - otherwise enable=0, select=0 when the same test passes against the upper pair;
  - otherwise enable=1, select=0.
- R9: With neither load nor step asserted, the code, the bypass bits and the error flag hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Load the code from the ld_* inputs |
| ld_coarse | input | 1 | Coarse field to load |
| ld_clk_dly | input | 2 | Clock-delay field to load |
| ld_tap | input | 4 | Tap field to load |
| ld_pi | input | 3 | Interpolator field to load |
| step | input | 1 | Single-cycle request to advance the code one increment |
| speed | input | 2 | Memory speed select (0, 1, 2; 3 acts as 0) |
| coarse | output | 1 | Current coarse field |
| clk_dly | output | 2 | Current clock-delay field |
| tap | output | 4 | Current tap field |
| pi | output | 3 | Current interpolator field |
| byp_en | output | 1 | Bypass enable bit |
| byp_sel | output | 1 | Bypass select bit |
| ovf | output | 1 | Sticky overflow error |

## Verification
The bench walks the complete step sequence from a zero code to overflow at every speed code. It therefore hits:
- the speed-dependent tap wrap, which a wrong maximum would shift by several steps;
- the clock-delay carry;
- the coarse carry that must move clock-delay back to 1, which a plain increment would push to 3.

Loading every tap and interpolator pair at every speed sweeps the bypass decision. This exposes a swapped threshold or a strict-versus-equal comparison error at each boundary, including the upper interpolator threshold of 4 at speed code 2, which is below the lower one. Separate cases cover:
- the error flag: a flag that cleared on the next step, or a frozen code that still moved;
- load winning over a simultaneous step;
- holding when idle.

// File: rtl/dcs_pkg.sv
package dcs_pkg;

  localparam int CW = 1;   // coarse width
  localparam int DW = 2;   // clock-delay width
  localparam int TW = 4;   // tap width
  localparam int PW = 3;   // interpolator width

  localparam logic [PW-1:0] PI_LAST     = PW'(6);
  localparam logic [DW-1:0] CLK_LAST    = DW'(2);
  localparam logic [CW-1:0] COARSE_LAST = CW'(1);

  typedef struct packed {
    logic [CW-1:0] coarse;
    logic [DW-1:0] clk_dly;
    logic [TW-1:0] tap;
    logic [PW-1:0] pi;
  } dly_code_t;

  typedef struct packed {
    logic [TW-1:0] tap_lo;
    logic [TW-1:0] tap_hi;
    logic [PW-1:0] pi_lo;
    logic [PW-1:0] pi_hi;
  } byp_thr_t;

  function automatic logic [TW-1:0] tap_limit(input logic [1:0] spd);
    case (spd)
      2'd1:    return TW'(10);
      2'd2:    return TW'(13);
      default: return TW'(12);
    endcase
  endfunction

  function automatic byp_thr_t thr_for(input logic [1:0] spd);
    byp_thr_t t;
    case (spd)
      2'd1:    begin t.tap_lo = TW'(2); t.tap_hi = TW'(8);  t.pi_lo = PW'(6); t.pi_hi = PW'(7); end
      2'd2:    begin t.tap_lo = TW'(3); t.tap_hi = TW'(11); t.pi_lo = PW'(6); t.pi_hi = PW'(4); end
      default: begin t.tap_lo = TW'(3); t.tap_hi = TW'(10); t.pi_lo = PW'(2); t.pi_hi = PW'(3); end
    endcase
    return t;
  endfunction

  // one odometer increment; code returned unchanged when no increment exists
  function automatic dly_code_t bump(input dly_code_t c, input logic [TW-1:0] tmax);
    dly_code_t n = c;
    if (c.pi < PI_LAST) begin
      n.pi = c.pi + PW'(1);
    end else if (c.tap < tmax) begin
      n.pi  = '0;
      n.tap = c.tap + TW'(1);
    end else if (c.clk_dly < CLK_LAST) begin
      n.pi      = '0;
      n.tap     = '0;
      n.clk_dly = c.clk_dly + DW'(1);
    end else if (c.coarse < COARSE_LAST) begin
      n.pi      = '0;
      n.tap     = '0;
      n.clk_dly = c.clk_dly - DW'(1);
      n.coarse  = c.coarse + CW'(1);
    end
    return n;
  endfunction

  function automatic logic exhausted(input dly_code_t c, input logic [TW-1:0] tmax);
    return (c.pi >= PI_LAST) && (c.tap >= tmax) &&
           (c.clk_dly >= CLK_LAST) && (c.coarse >= COARSE_LAST);
  endfunction

  // returns {enable, select}
  function automatic logic [1:0] bypass_bits(input dly_code_t c, input byp_thr_t t);
    if ((c.tap < t.tap_lo) || ((c.tap == t.tap_lo) && (c.pi < t.pi_lo)))
      return 2'b11;
    else if ((c.tap < t.tap_hi) || ((c.tap == t.tap_hi) && (c.pi < t.pi_hi)))
      return 2'b00;
    else
      return 2'b10;
  endfunction

endpackage

// File: rtl/dcs_speed_table.sv
module dcs_speed_table
  import dcs_pkg::*;
(
  input  logic [1:0]    speed,
  output logic [TW-1:0] tap_max,
  output byp_thr_t      thr
);
  always_comb begin
    tap_max = tap_limit(speed);
    thr     = thr_for(speed);
  end
endmodule

// File: rtl/dcs_advance.sv
module dcs_advance
  import dcs_pkg::*;
(
  input  dly_code_t     cur,
  input  logic [TW-1:0] tap_max,
  output dly_code_t     nxt,
  output logic          at_limit
);
  always_comb begin
    at_limit = exhausted(cur, tap_max);
    nxt      = at_limit ? cur : bump(cur, tap_max);
  end
endmodule

// File: rtl/dcs_bypass.sv
module dcs_bypass
  import dcs_pkg::*;
(
  input  dly_code_t code,
  input  byp_thr_t  thr,
  output logic      en,
  output logic      sel
);
  always_comb {en, sel} = bypass_bits(code, thr);
endmodule

// File: rtl/dcs_stepper.sv
module dcs_stepper
  import dcs_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] ld_coarse,
  input  logic [DW-1:0] ld_clk_dly,
  input  logic [TW-1:0] ld_tap,
  input  logic [PW-1:0] ld_pi,
  input  logic          step,
  input  logic [1:0]    speed,
  output logic [CW-1:0] coarse,
  output logic [DW-1:0] clk_dly,
  output logic [TW-1:0] tap,
  output logic [PW-1:0] pi,
  output logic          byp_en,
  output logic          byp_sel,
  output logic          ovf
);
  dly_code_t     code_q, code_nxt, ld_code, cand;
  logic [TW-1:0] tap_max;
  byp_thr_t      thr;
  logic          step_ovf;   // step would exceed the last code
  logic          step_go;    // step accepted this cycle
  logic          cand_en, cand_sel;

  assign ld_code = '{coarse: ld_coarse, clk_dly: ld_clk_dly, tap: ld_tap, pi: ld_pi};
  assign step_go = step && !load;
  assign cand    = load ? ld_code : code_nxt;

  dcs_speed_table u_tbl (.speed(speed), .tap_max(tap_max), .thr(thr));
  dcs_advance     u_adv (.cur(code_q), .tap_max(tap_max), .nxt(code_nxt), .at_limit(step_ovf));
  dcs_bypass      u_byp (.code(cand), .thr(thr), .en(cand_en), .sel(cand_sel));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q  <= '0;
      byp_en  <= 1'b1;
      byp_sel <= 1'b1;
      ovf     <= 1'b0;
    end else if (load) begin
      code_q  <= cand;
      byp_en  <= cand_en;
      byp_sel <= cand_sel;
      ovf     <= 1'b0;
    end else if (step) begin
      code_q  <= cand;
      byp_en  <= cand_en;
      byp_sel <= cand_sel;
      ovf     <= ovf | step_ovf;
    end
  end

  assign coarse  = code_q.coarse;
  assign clk_dly = code_q.clk_dly;
  assign tap     = code_q.tap;
  assign pi      = code_q.pi;
endmodule

// File: rtl/dcs_stepper_chk.sv
module dcs_stepper_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       load,
  input logic       step_go,
  input logic       step_ovf,
  input logic [9:0] code,
  input logic       byp_en,
  input logic       byp_sel,
  input logic       ovf
);
  // R2
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !ovf);
  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && step_ovf) |=> (ovf && $stable(code)));
  // R7
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !load) |=> ovf);
  // R3
  step_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_go && !step_ovf) |=> (code != $past(code)));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step_go) |=> ($stable(code) && $stable(ovf) && $stable(byp_en)));
  // R8
  byp_combo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byp_sel |-> byp_en);
endmodule

bind dcs_stepper dcs_stepper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load(load), .step_go(step_go), .step_ovf(step_ovf),
  .code({coarse, clk_dly, tap, pi}), .byp_en(byp_en), .byp_sel(byp_sel), .ovf(ovf)
);

// File: tb/dcs_stepper_test.sv
module dcs_stepper_test;
  logic clk = 0, rst_n = 0, load = 0, step = 0;
  logic [0:0] ld_coarse = '0;
  logic [1:0] ld_clk_dly = '0, speed = '0;
  logic [3:0] ld_tap = '0;
  logic [2:0] ld_pi = '0;
  logic [0:0] coarse;
  logic [1:0] clk_dly;
  logic [3:0] tap;
  logic [2:0] pi;
  logic byp_en, byp_sel, ovf;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  dcs_stepper uut (.*);

  // observed word: {coarse, clk_dly, tap, pi, en, sel, ovf}
  function automatic logic [12:0] obs();
    return {coarse, clk_dly, tap, pi, byp_en, byp_sel, ovf};
  endfunction

  function automatic int tmax_of(int s);
    return (s == 1) ? 10 : (s == 2) ? 13 : 12;
  endfunction

  // bypass via a linear position tap*8+pi against threshold positions
  function automatic logic [1:0] exp_byp(int s, int t, int p);
    int lo, hi, pos;
    pos = t * 8 + p;
    if (s == 1)      begin lo = 2*8+6; hi = 8*8+7;  end
    else if (s == 2) begin lo = 3*8+6; hi = 11*8+4; end
    else             begin lo = 3*8+2; hi = 10*8+3; end
    if (pos < lo) return 2'b11;
    if (pos < hi) return 2'b00;
    return 2'b10;
  endfunction

  // code after n steps from zero: five stages of (tmax+1)*7 positions
  function automatic logic [12:0] exp_seq(int s, int n, logic e);
    int seg, st, r, c, k;
    seg = (tmax_of(s) + 1) * 7;
    st = n / seg; r = n % seg;
    case (st)
      0: begin c = 0; k = 0; end
      1: begin c = 0; k = 1; end
      2: begin c = 0; k = 2; end
      3: begin c = 1; k = 1; end
      default: begin c = 1; k = 2; end
    endcase
    return {c[0], k[1:0], 4'(r / 7), 3'(r % 7), exp_byp(s, r / 7, r % 7), e};
  endfunction

  task automatic check(string req, logic [12:0] exp);
    n_chk++;
    if (obs() !== exp) begin
      n_fail++;
      $display("FAIL %s got %b expected %b", req, obs(), exp);
    end
  endtask

  task automatic do_load(int c, int k, int t, int p, logic with_step);
    ld_coarse = 1'(c); ld_clk_dly = 2'(k); ld_tap = 4'(t); ld_pi = 3'(p);
    load = 1; step = with_step;
    @(negedge clk);
    load = 0; step = 0;
  endtask

  task automatic do_step();
    step = 1;
    @(negedge clk);
    step = 0;
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 13'b0_00_0000_000_11_0);
    rst_n = 1;
    @(negedge clk);
    check("R1 after reset", 13'b0_00_0000_000_11_0);

    for (int s = 0; s < 4; s++) begin
      int total;
      speed = 2'(s);
      total = 5 * (tmax_of(s) + 1) * 7 - 1;
      do_load(0, 0, 0, 0, 0);
      check("R2 load zero", exp_seq(s, 0, 0));
      // R3 R4 R5 R6: full walk
      for (int n = 1; n <= total; n++) begin
        do_step();
        check("R3/R4/R5/R6 step walk", exp_seq(s, n, 0));
      end
      // R7: step at the last code
      do_step();
      check("R7 overflow", exp_seq(s, total, 1));
      do_step();
      check("R7 sticky", exp_seq(s, total, 1));
      repeat (2) @(negedge clk);
      check("R9 idle hold", exp_seq(s, total, 1));
      do_load(1, 1, 0, 0, 0);
      check("R2 load clears ovf", {1'b1, 2'd1, 4'd0, 3'd0, exp_byp(s, 0, 0), 1'b0});
      // R8: exhaustive bypass through loads
      for (int t = 0; t < 16; t++)
        for (int p = 0; p < 8; p++) begin
          do_load(0, 0, t, p, 0);
          check("R8 bypass", {1'b0, 2'd0, 4'(t), 3'(p), exp_byp(s, t, p), 1'b0});
        end
    end

    // R6: coarse carry from a loaded code at speed 1
    speed = 2'd1;
    do_load(0, 2, 10, 6, 0);
    do_step();
    check("R6 coarse carry", {1'b1, 2'd1, 4'd0, 3'd0, 2'b11, 1'b0});
    // R5: clock-delay carry
    do_load(0, 0, 10, 6, 0);
    do_step();
    check("R5 clk carry", {1'b0, 2'd1, 4'd0, 3'd0, 2'b11, 1'b0});
    // R2: load wins over step
    do_load(0, 1, 5, 6, 1);
    check("R2 load priority", {1'b0, 2'd1, 4'd5, 3'd6, exp_byp(1, 5, 6), 1'b0});
    // R9: idle hold after a normal step
    do_step();
    repeat (3) @(negedge clk);
    check("R9 hold", {1'b0, 2'd1, 4'd6, 3'd0, exp_byp(1, 6, 0), 1'b0});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule